// File: doc/BRIEF.md
# Chained Masked Vector Multiply-Add Pipeline

This block computes, element by element over a whole vector, `d[i] = a[i] * b[i] + c[i]` in integer arithmetic. It models two fully pipelined functional units: a multiplier with a start-up latency of 7 cycles and an adder with a start-up latency of 6 cycles. Each unit accepts one element per cycle. The operand elements come from vector-register read ports that the block addresses itself. The read data is expected back combinationally in the same cycle. Results leave through a write port that carries an element index.

A per-element predicate vector decides which destination elements are written. Elements that are disabled still pass through both pipelines, so element indices stay in step, but their write strobe is held low. A mode input, sampled only when an operation is accepted, selects between two behaviours:
- **Forwarded mode:** each product goes straight into the adder in the cycle it leaves the multiplier.
- **Serial mode:** every product is parked in a buffer, and the adds start only once the last product exists.

When the operation ends, the block reports the number of cycles from the first multiply issue to the last write-back.

Top module: `vmac_chain`

## Requirements
- R1: Each write-back carries, for element i, `(a[i] * b[i] + c[i]) mod 2^DW`, where a and b are the values read at multiply index i and c is the value read at add index i.
- R2: With `chain_en` = 1 at start, element i is written back exactly MUL_LAT + ADD_LAT cycles after its multiply issue. With defaults, the last write-back lands 77 cycles after the first issue, counting both end cycles.
- R3: With `chain_en` = 0 at start, no add is issued until the cycle after the last product leaves the multiplier. Element i is written back VLEN + MUL_LAT + ADD_LAT cycles after its multiply issue, which gives 141 cycles in total with defaults.
- R4: Bit i of `mask` (captured at the accepted start) gates element i. A 1 raises `wr_en` in that element's write-back cycle. A 0 keeps `wr_en` low in that cycle and leaves the destination element unchanged, while the element still occupies its slot.
- R5: One cycle after the last element's write-back slot, `done` pulses high for one cycle. In that cycle `lat_cycles` holds the inclusive cycle count from the first multiply issue to the last write-back slot (77 forwarded, 141 serial).
- R6: The first multiply read (`mul_rd_en` with index 0) happens in the cycle after the accepted start. Indices 0 to VLEN-1 are then read on consecutive cycles.
- R7: A `start` pulse while `busy` is high is ignored: it changes neither the mode, nor the mask, nor the schedule of the running operation.
- R8: After reset, `busy`, `wr_en`, `mul_rd_en`, `done` and `lat_cycles` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| chain_en | input | 1 | 1 = forward products element by element, 0 = serial; sampled at start |
| mask | input | VLEN | Per-element write predicate; bit i for element i, sampled at start |
| busy | output | 1 | Operation in progress |
| mul_rd_en | output | 1 | Multiplier operand read strobe |
| mul_rd_idx | output | $clog2(VLEN) | Element index for the multiplier operands |
| mul_a | input | DW | First multiplier operand at `mul_rd_idx` |
| mul_b | input | DW | Second multiplier operand at `mul_rd_idx` |
| add_rd_en | output | 1 | Addend read strobe |
| add_rd_idx | output | $clog2(VLEN) | Element index for the addend |
| add_c | input | DW | Addend at `add_rd_idx` |
| wr_en | output | 1 | Destination write strobe (low for disabled elements) |
| wr_idx | output | $clog2(VLEN) | Destination element index |
| wr_data | output | DW | Result element |
| done | output | 1 | One-cycle end-of-operation pulse |
| lat_cycles | output | CW | Total cycles of the finished operation |

## Verification
The bench builds the block with its default parameters: a 64-element vector, 16-bit elements, a 7-cycle multiplier and a 6-cycle adder. With these values the 77-cycle forwarded total and the 141-cycle serial total both come within reach, and each can be compared exactly. A behavioural model recomputes every element's expected write cycle, index and value from the start cycle and mode. That model is compared against the ports on every clock. An eight-register, 64-element vector file in the bench absorbs the writes, so disabled elements can be seen to keep their old contents. The stimulus covers all-ones, alternating, irregular and all-zero predicates, 16-bit wrap-around operands, and a start pulse mid-operation.

// File: rtl/vmac_pkg.sv
`timescale 1ns/1ps
// Package: shared types and derived cycle totals for the vector multiply-add pipeline.
// Assumes latencies and vector length are small positive integers.
package vmac_pkg;

    typedef enum logic {
        MODE_SERIAL  = 1'b0,
        MODE_FORWARD = 1'b1
    } vmac_mode_e;

    // Cycles from first issue to last write-back when products are forwarded.
    function automatic int fwd_total(int vlen, int mlat, int alat);
        return vlen + mlat + alat;
    endfunction

    // Cycles from first issue to last write-back when adds wait for all products.
    function automatic int ser_total(int vlen, int mlat, int alat);
        return 2 * vlen + mlat + alat;
    endfunction

endpackage

// File: rtl/vmac_pipe.sv
`timescale 1ns/1ps
// Module: fixed-latency pipeline carrying a valid bit and a payload.
// An input presented in cycle t appears at the output in cycle t+LAT.
// Assumes LAT >= 1; payload stages are not reset, only valid bits are.
module vmac_pipe #(
    parameter int LAT = 7,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_vld,
    input  logic [W-1:0] in_pay,
    output logic         out_vld,
    output logic [W-1:0] out_pay
);
    logic [LAT-1:0] vld;
    logic [W-1:0]   pay [LAT];

    for (genvar g = 0; g < LAT; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Stage 0 captures the incoming element.
            always_ff @(posedge clk) begin
                if (!rst_n) vld[0] <= 1'b0;
                else        vld[0] <= in_vld;
                pay[0] <= in_pay;
            end
        end else begin : g_next
            // Later stages shift the element one step per cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) vld[g] <= 1'b0;
                else        vld[g] <= vld[g-1];
                pay[g] <= pay[g-1];
            end
        end
    end

    assign out_vld = vld[LAT-1];
    assign out_pay = pay[LAT-1];

endmodule

// File: rtl/vmac_ctrl.sv
`timescale 1ns/1ps
// Module: sequencer for the vector multiply-add pipeline.
// Accepts a start while idle and captures mode and predicate.
// Issues multiply indices on consecutive cycles and, in serial mode, issues the add
// indices after the last product. Ends on the last element's write-back slot.
// Assumes the result and product streams come from the datapath pipelines.
module vmac_ctrl
    import vmac_pkg::*;
#(
    parameter int VLEN    = 64,
    parameter int MUL_LAT = 7,
    parameter int ADD_LAT = 6,
    parameter int CW      = 16,
    localparam int IW     = $clog2(VLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            chain_en,
    input  logic [VLEN-1:0] mask_in,
    input  logic            prod_vld,
    input  logic [IW-1:0]   prod_idx,
    input  logic            res_vld,
    input  logic [IW-1:0]   res_idx,
    output logic            run,
    output vmac_mode_e      mode,
    output logic [VLEN-1:0] mask_q,
    output logic            mul_iss,
    output logic [IW-1:0]   mul_idx,
    output logic            add_iss,
    output logic [IW-1:0]   add_idx,
    output logic            done,
    output logic [CW-1:0]   lat
);
    localparam logic [IW-1:0] LAST_IDX  = IW'(VLEN - 1);
    localparam logic [IW:0]   VLEN_C    = (IW+1)'(VLEN);
    localparam logic [CW-1:0] FWD_CYC   = CW'(fwd_total(VLEN, MUL_LAT, ADD_LAT));
    localparam logic [CW-1:0] SER_CYC   = CW'(ser_total(VLEN, MUL_LAT, ADD_LAT));

    logic          run_q, add_ph_q, done_q;
    vmac_mode_e    mode_q;
    logic [IW:0]   mi_q;
    logic [IW-1:0] ai_q;
    logic [CW-1:0] cnt_q, lat_q;

    assign mul_iss = run_q && (mi_q < VLEN_C);
    assign mul_idx = mi_q[IW-1:0];

    // Sequencing of start capture, issue counters, cycle count and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            mode_q   <= MODE_SERIAL;
            mask_q   <= '0;
            add_ph_q <= 1'b0;
            mi_q     <= '0;
            ai_q     <= '0;
            cnt_q    <= '0;
            lat_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!run_q) begin
                if (start) begin
                    run_q    <= 1'b1;
                    mode_q   <= vmac_mode_e'(chain_en);
                    mask_q   <= mask_in;
                    add_ph_q <= 1'b0;
                    mi_q     <= '0;
                    ai_q     <= '0;
                    cnt_q    <= '0;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (mul_iss) mi_q <= mi_q + 1'b1;
                if (mode_q == MODE_SERIAL && prod_vld && prod_idx == LAST_IDX)
                    add_ph_q <= 1'b1;
                if (add_ph_q) begin
                    if (ai_q == LAST_IDX) add_ph_q <= 1'b0;
                    else                  ai_q     <= ai_q + 1'b1;
                end
                if (res_vld && res_idx == LAST_IDX) begin
                    run_q  <= 1'b0;
                    done_q <= 1'b1;
                    lat_q  <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign run     = run_q;
    assign mode    = mode_q;
    assign add_iss = add_ph_q;
    assign add_idx = ai_q;
    assign done    = done_q;
    assign lat     = lat_q;

    // R7: mode and predicate hold for the whole operation.
    a_r7_capture_hold: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && $past(run_q) |-> $stable(mode_q) && $stable(mask_q));
    // R3: in serial mode no add is issued while multiplies are still issuing.
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SERIAL) && add_ph_q |-> !mul_iss);
    // R5: completion is a single-cycle pulse taken while idle.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !run_q);
    // R2, R3: reported total matches the mode's cycle budget.
    a_r5_lat_value: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> lat_q == ((mode_q == MODE_FORWARD) ? FWD_CYC : SER_CYC));
    // R6: multiply indices advance by one on consecutive issue cycles.
    a_r6_issue_step: assert property (@(posedge clk) disable iff (!rst_n)
        mul_iss && $past(mul_iss) |-> mul_idx == ($past(mul_idx) + 1'b1));

endmodule

// File: rtl/vmac_chain.sv
`timescale 1ns/1ps
// Module: top of the vector multiply-add pipeline with optional element forwarding.
// The product of each element travels MUL_LAT cycles, then the add travels ADD_LAT cycles.
// Forwarded mode feeds products straight to the adder. Serial mode buffers all VLEN
// products first. Disabled elements keep their slot but their write strobe stays low.
// Assumes operand read data returns combinationally in the cycle of the read index.
module vmac_chain
    import vmac_pkg::*;
#(
    parameter int VLEN    = 64,
    parameter int DW      = 16,
    parameter int MUL_LAT = 7,
    parameter int ADD_LAT = 6,
    parameter int CW      = 16,
    localparam int IW     = $clog2(VLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            chain_en,
    input  logic [VLEN-1:0] mask,
    output logic            busy,
    output logic            mul_rd_en,
    output logic [IW-1:0]   mul_rd_idx,
    input  logic [DW-1:0]   mul_a,
    input  logic [DW-1:0]   mul_b,
    output logic            add_rd_en,
    output logic [IW-1:0]   add_rd_idx,
    input  logic [DW-1:0]   add_c,
    output logic            wr_en,
    output logic [IW-1:0]   wr_idx,
    output logic [DW-1:0]   wr_data,
    output logic            done,
    output logic [CW-1:0]   lat_cycles
);
    localparam int PW = 1 + IW + DW;

    logic            run, mul_iss, add_iss;
    vmac_mode_e      mode;
    logic [VLEN-1:0] mask_q;
    logic [IW-1:0]   mul_idx, add_idx;

    logic            p_vld, r_vld;
    logic [PW-1:0]   p_pay, r_pay;
    logic            p_mask, r_mask;
    logic [IW-1:0]   p_idx, r_idx;
    logic [DW-1:0]   p_data, r_sum;

    logic            a_vld, a_mask;
    logic [IW-1:0]   a_idx;
    logic [DW-1:0]   a_prod, prod_now, sum_now;
    logic [DW-1:0]   prod_buf [VLEN];

    vmac_ctrl #(.VLEN(VLEN), .MUL_LAT(MUL_LAT), .ADD_LAT(ADD_LAT), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_en(chain_en), .mask_in(mask),
        .prod_vld(p_vld), .prod_idx(p_idx), .res_vld(r_vld), .res_idx(r_idx),
        .run(run), .mode(mode), .mask_q(mask_q),
        .mul_iss(mul_iss), .mul_idx(mul_idx), .add_iss(add_iss), .add_idx(add_idx),
        .done(done), .lat(lat_cycles)
    );

    assign prod_now = mul_a * mul_b;

    vmac_pipe #(.LAT(MUL_LAT), .W(PW)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .in_vld(mul_iss), .in_pay({mask_q[mul_idx], mul_idx, prod_now}),
        .out_vld(p_vld), .out_pay(p_pay)
    );
    assign {p_mask, p_idx, p_data} = p_pay;

    // Park products for serial mode until the whole multiply has drained.
    always_ff @(posedge clk) begin
        if (p_vld && mode == MODE_SERIAL) prod_buf[p_idx] <= p_data;
    end

    // Select the adder's source: live product stream or the parked buffer.
    always_comb begin
        if (mode == MODE_FORWARD) begin
            a_vld  = p_vld;
            a_idx  = p_idx;
            a_mask = p_mask;
            a_prod = p_data;
        end else begin
            a_vld  = add_iss;
            a_idx  = add_idx;
            a_mask = mask_q[add_idx];
            a_prod = prod_buf[add_idx];
        end
    end

    assign sum_now = a_prod + add_c;

    vmac_pipe #(.LAT(ADD_LAT), .W(PW)) u_add (
        .clk(clk), .rst_n(rst_n),
        .in_vld(a_vld), .in_pay({a_mask, a_idx, sum_now}),
        .out_vld(r_vld), .out_pay(r_pay)
    );
    assign {r_mask, r_idx, r_sum} = r_pay;

    assign busy       = run;
    assign mul_rd_en  = mul_iss;
    assign mul_rd_idx = mul_idx;
    assign add_rd_en  = a_vld;
    assign add_rd_idx = a_idx;
    assign wr_en      = r_vld && r_mask;
    assign wr_idx     = r_idx;
    assign wr_data    = r_sum;

    // R4: a write only happens for an element whose captured predicate bit is set.
    a_r4_wr_masked: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> mask_q[wr_idx]);
    // R2: write-back slots leave the adder in ascending element order.
    a_r2_wb_order: assert property (@(posedge clk) disable iff (!rst_n)
        r_vld && $past(r_vld) |-> r_idx == ($past(r_idx) + 1'b1));
    // R8: no write strobe outside an operation.
    a_r8_wr_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
    // R6: multiply reads only while an operation runs.
    a_r6_rd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mul_rd_en |-> busy);

endmodule

// File: tb/vmac_chain_test.sv
`timescale 1ns/1ps
// Bench: behavioural schedule model compared with the ports on every falling edge.
module vmac_chain_test;
    localparam int VL = 64, DW = 16, ML = 7, AL = 6, CW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 1'b0, chain_en = 1'b0;
    logic [VL-1:0] mask = '0;
    logic busy, mul_rd_en, add_rd_en, wr_en, done;
    logic [5:0] mul_rd_idx, add_rd_idx, wr_idx;
    logic [DW-1:0] mul_a, mul_b, add_c, wr_data;
    logic [CW-1:0] lat_cycles;

    logic [DW-1:0] vrf [8][VL];
    logic [2:0] ra = 0, rb = 1, rc = 2, rd = 3;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int s0 = 0;
    bit act = 1'b0, md = 1'b0;
    logic [VL-1:0] em = '0;
    logic [DW-1:0] ex [VL];
    logic [DW-1:0] old [VL];

    always #2 clk = ~clk;

    vmac_chain #(.VLEN(VL), .DW(DW), .MUL_LAT(ML), .ADD_LAT(AL), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .chain_en(chain_en), .mask(mask),
        .busy(busy), .mul_rd_en(mul_rd_en), .mul_rd_idx(mul_rd_idx),
        .mul_a(mul_a), .mul_b(mul_b),
        .add_rd_en(add_rd_en), .add_rd_idx(add_rd_idx), .add_c(add_c),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .done(done), .lat_cycles(lat_cycles)
    );

    assign mul_a = vrf[ra][mul_rd_idx];
    assign mul_b = vrf[rb][mul_rd_idx];
    assign add_c = vrf[rc][add_rd_idx];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (wr_en) vrf[rd][wr_idx] <= wr_data;
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the behavioural schedule.
    always @(negedge clk) begin
        if (rst_n) begin
            if (act) begin
                int rel, base, lastwb, i;
                rel    = cyc - s0 - 1;
                base   = md ? (ML + AL) : (VL + ML + AL);
                lastwb = base + VL - 1;
                i      = rel - base;
                chk("R6 mul_rd_en", mul_rd_en, (rel >= 0 && rel < VL));
                if (rel >= 0 && rel < VL) chk("R6 mul_rd_idx", mul_rd_idx, rel);
                if (i >= 0 && i < VL) begin
                    chk("R4 wr_en", wr_en, em[i]);
                    if (em[i]) begin
                        chk(md ? "R2 wr_idx" : "R3 wr_idx", wr_idx, i);
                        chk("R1 wr_data", wr_data, ex[i]);
                    end
                end else begin
                    chk("R4 wr_en outside slots", wr_en, 0);
                end
                chk("R5 done", done, (rel == lastwb + 1));
                if (rel == lastwb + 1) begin
                    chk(md ? "R2 lat_cycles" : "R3 lat_cycles", lat_cycles, lastwb + 1);
                    act = 1'b0;
                end
            end else begin
                chk("R8 idle wr_en", wr_en, 0);
                chk("R8 idle done", done, 0);
            end
        end
    end

    task automatic run_op(logic [2:0] a, logic [2:0] b, logic [2:0] c, logic [2:0] d,
                          logic [VL-1:0] m, bit ch, bit poke);
        @(negedge clk);
        ra = a; rb = b; rc = c; rd = d;
        for (int k = 0; k < VL; k++) begin
            ex[k]  = DW'(vrf[a][k] * vrf[b][k] + vrf[c][k]);
            old[k] = vrf[d][k];
        end
        em = m; md = ch;
        mask = m; chain_en = ch; start = 1'b1;
        s0 = cyc; act = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 400 && act; k++) begin
            @(negedge clk);
            if (poke && k == 20) begin
                start = 1'b1; chain_en = ~ch; mask = ~m;   // R7: must be ignored
            end else begin
                start = 1'b0; chain_en = ch; mask = m;
            end
        end
        start = 1'b0;
        if (act) begin
            n_chk++; n_fail++; act = 1'b0;
            $display("FAIL R5: operation did not finish, actual busy %0d expected done", busy);
        end
        @(negedge clk);
        for (int k = 0; k < VL; k++)
            chk("R4 dest contents", vrf[d][k], m[k] ? ex[k] : old[k]);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < VL; k++)
                vrf[r][k] = DW'((r * 977 + k * 131 + (k * k) * 7) ^ (r << 9));
        for (int k = 0; k < VL; k++) begin
            vrf[5][k] = 16'hFFFF;
            vrf[6][k] = DW'(16'hFFFF - k);
            vrf[7][k] = 16'h8000;
        end
        repeat (3) @(negedge clk);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset wr_en", wr_en, 0);
        chk("R8 reset mul_rd_en", mul_rd_en, 0);
        chk("R8 reset done", done, 0);
        chk("R8 reset lat", lat_cycles, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R2: forwarded, every element enabled
        run_op(0, 1, 2, 3, {VL{1'b1}}, 1'b1, 1'b0);
        // R3, R7: serial, alternating predicate, stray start mid-run
        run_op(0, 1, 2, 4, {(VL/2){2'b10}}, 1'b0, 1'b1);
        // R1: wrap-around operands, irregular predicate, forwarded, stray start
        run_op(5, 6, 7, 3, 64'hDEAD_BEEF_0F0F_A5C3, 1'b1, 1'b1);
        // R4: nothing enabled, serial; slots still take the full time
        run_op(0, 1, 2, 4, '0, 1'b0, 1'b0);
        // R1: serial with wrap-around operands, all enabled
        run_op(6, 5, 7, 0, {VL{1'b1}}, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule